// File: doc/BRIEF.md
# Colour Panel Controller Register Block

This block is the register front end of a colour flat-panel display controller. A host reaches it through an APB-style slave port that spans a 4 KB byte window. It holds four timing words, the base addresses of the upper and lower panel halves, a control word, and an interrupt mask and status pair. Palette storage, pixel fetch and video timing generation sit elsewhere in the design. That downstream logic reads its setup from this block's decoded outputs: panel width and height, pixel depth, ordering flags, the two base addresses and a qualified display enable.

A build-time parameter `NEW_MAP` picks between two register layouts. The older layout, with `NEW_MAP=0`, puts the interrupt mask at word 6 and the control word at word 7. The newer layout swaps those two words and uses a different identification byte sequence. The block raises a one-cycle pulse after every write to a timing or control word, so that display logic can resize or redraw. Interrupt sources set status bits through `int_set`, and software clears them by writing ones to a clear word.

Top module: `lcd_regif`

## Requirements
- R1: After synchronous reset every register is zero. `panel_width` is then 16, `panel_height` is 1, `disp_en` is 0, `irq` is 0 and `cfg_pulse` is 0.
- R2: Word offsets 0 to 3 hold timing words 0 to 3, word 4 holds the upper base address and word 5 holds the lower base address. Each is 32 bits wide and reads back what was written. `upper_base` and `lower_base` show words 4 and 5.
- R3: With `NEW_MAP=0`, word 6 is the interrupt mask and word 7 is the control word. With `NEW_MAP=1`, word 6 is the control word and word 7 is the mask.
- R4: `panel_width` equals (timing0[7:2] + 1) * 16, and the other timing0 bits have no effect on it. `panel_height` equals timing1[9:0] + 1, and the other timing1 bits have no effect on it.
- R5: `disp_en` is high only when control bit 0 (enable) and control bit 11 (power) are both set.
- R6: The control outputs decode as follows: `bpp_mode` is control bits [3:1], `bgr` is bit 8, `be_byte` is bit 9 and `be_pixel` is bit 10. Control bits above 11 read back as zero.
- R7: A high bit of `int_set` sets the matching status bit. Word 8 reads the raw status, word 9 reads the status ANDed with the mask, and `irq` is the OR of the masked status.
- R8: A write to word 10 clears each status bit that is 1 in the written data. If a source sets a bit in the same cycle that the write clears it, the set wins.
- R9: Byte offsets 0xFE0 to 0xFFF return one identification byte per word, with the index taken from address bits [4:2]. The older sequence is 10, 11, 04, 00, 0D, F0, 05, B1 (hex). The newer one begins 11, 11, 24, 00 and continues the same way.
- R10: Words 11 and 12 read as zero. Reads of unmapped offsets return zero, and writes to unmapped or read-only offsets change no register and raise no pulse.
- R11: `cfg_pulse` is high for exactly the one cycle after a write to words 0 to 3 or to the control word, and stays low after any other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write strobe when high |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| int_set | input | IRQ_W | Interrupt sources, one status bit each |
| irq | output | 1 | OR of the masked status |
| disp_en | output | 1 | Enable and power both set |
| bpp_mode | output | 3 | Pixel depth code |
| bgr | output | 1 | Swap red and blue |
| be_byte | output | 1 | Big-endian byte order |
| be_pixel | output | 1 | Big-endian pixel order in a byte |
| panel_width | output | 11 | Decoded width in pixels |
| panel_height | output | 11 | Decoded height in lines |
| upper_base | output | 32 | Upper panel base address |
| lower_base | output | 32 | Lower panel base address |
| cfg_pulse | output | 1 | One-cycle flag after a timing or control write |

## Verification
The hardest case to reach is the same-cycle collision in the status register, where a source raises a bit in the very cycle that a clear write lowers it. The bench holds `int_set` high for the whole length of a clear transfer, so the two events are sure to land on the same edge. The variant swap is harder to see from a single instance. The bench therefore drives one bus into two instances, one per layout, so that a single write to word 6 or word 7 must change the mask in one instance and the control word in the other.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int CTRL_W   = 12;
    localparam int GEOM_W   = 11;
    localparam int N_TIMING = 4;
    localparam logic [ADDR_W-1:0] ID_BASE = 12'hFE0;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_TIM, SEL_UBASE, SEL_LBASE, SEL_MASK, SEL_CTRL,
        SEL_RAW, SEL_MSKD, SEL_CLR, SEL_CUR, SEL_ID
    } reg_sel_e;

    typedef struct packed {
        logic       power;
        logic       be_pix;
        logic       be_byte;
        logic       bgr;
        logic [2:0] bpp;
        logic       enable;
    } ctrl_fields_t;

    function automatic ctrl_fields_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_fields_t f;
        f.enable  = w[0];
        f.bpp     = w[3:1];
        f.bgr     = w[8];
        f.be_byte = w[9];
        f.be_pix  = w[10];
        f.power   = w[11];
        return f;
    endfunction

    function automatic logic [7:0] id_byte(input logic newer, input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = newer ? 8'h11 : 8'h10;
            3'd1:    b = 8'h11;
            3'd2:    b = newer ? 8'h24 : 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
    import lcdc_pkg::*;
#(
    parameter bit NEW_MAP = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [2:0]        idx
);
    localparam logic [9:0] WORD_A = 10'd6;
    localparam logic [9:0] WORD_B = 10'd7;

    reg_sel_e sel_a;
    reg_sel_e sel_b;
    logic [9:0] word;
    logic unused_addr;

    generate
        if (NEW_MAP) begin : g_new
            assign sel_a = SEL_CTRL;
            assign sel_b = SEL_MASK;
        end else begin : g_old
            assign sel_a = SEL_MASK;
            assign sel_b = SEL_CTRL;
        end
    endgenerate

    assign word        = addr[ADDR_W-1:2];
    assign unused_addr = ^addr[1:0];

    always_comb begin
        sel = SEL_NONE;
        idx = 3'd0;
        if (addr >= ID_BASE) begin
            sel = SEL_ID;
            idx = addr[4:2];
        end else if (word < 10'(N_TIMING)) begin
            sel = SEL_TIM;
            idx = {1'b0, word[1:0]};
        end else begin
            case (word)
                10'd4:   sel = SEL_UBASE;
                10'd5:   sel = SEL_LBASE;
                WORD_A:  sel = sel_a;
                WORD_B:  sel = sel_b;
                10'd8:   sel = SEL_RAW;
                10'd9:   sel = SEL_MSKD;
                10'd10:  sel = SEL_CLR;
                10'd11,
                10'd12:  sel = SEL_CUR;
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq #(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] set_i,
    input  logic             mask_we,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] wdata,
    output logic [IRQ_W-1:0] mask_q,
    output logic [IRQ_W-1:0] status_q,
    output logic             irq
);
    logic [IRQ_W-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            status_q <= '0;
        end else begin
            if (mask_we) mask_q <= wdata;
            status_q <= (status_q & ~clr_bits) | set_i;
        end
    end

    assign irq = |(status_q & mask_q);
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom
    import lcdc_pkg::*;
(
    input  logic [DATA_W-1:0] tim0,
    input  logic [DATA_W-1:0] tim1,
    output logic [GEOM_W-1:0] width,
    output logic [GEOM_W-1:0] height
);
    logic [GEOM_W-1:0] word_units;
    logic unused_geom;

    // pixels per line advance in groups of 16
    assign word_units  = GEOM_W'(tim0[7:2]) + GEOM_W'(1);
    assign width       = word_units << 4;
    assign height      = GEOM_W'(tim1[9:0]) + GEOM_W'(1);
    assign unused_geom = ^{tim0[DATA_W-1:8], tim0[1:0], tim1[DATA_W-1:10]};
endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
    import lcdc_pkg::*;
#(
    parameter bit NEW_MAP = 1'b0,
    parameter int IRQ_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [IRQ_W-1:0]  int_set,
    output logic              irq,
    output logic              disp_en,
    output logic [2:0]        bpp_mode,
    output logic              bgr,
    output logic              be_byte,
    output logic              be_pixel,
    output logic [GEOM_W-1:0] panel_width,
    output logic [GEOM_W-1:0] panel_height,
    output logic [DATA_W-1:0] upper_base,
    output logic [DATA_W-1:0] lower_base,
    output logic              cfg_pulse
);
    reg_sel_e          sel;
    logic [2:0]        idx;
    logic              wr;
    logic [DATA_W-1:0] timing_q [N_TIMING];
    logic [DATA_W-1:0] ubase_q;
    logic [DATA_W-1:0] lbase_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [IRQ_W-1:0]  mask_q;
    logic [IRQ_W-1:0]  status_q;
    logic              pulse_q;
    ctrl_fields_t      cf;

    assign wr = psel && penable && pwrite;

    lcdc_addr_dec #(.NEW_MAP(NEW_MAP)) dec_i (
        .addr (paddr),
        .sel  (sel),
        .idx  (idx)
    );

    generate
        for (genvar t = 0; t < N_TIMING; t++) begin : g_tim
            always_ff @(posedge clk) begin
                if (rst)
                    timing_q[t] <= '0;
                else if (wr && sel == SEL_TIM && idx == 3'(t))
                    timing_q[t] <= pwdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ubase_q <= '0;
            lbase_q <= '0;
            ctrl_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            if (wr && sel == SEL_UBASE) ubase_q <= pwdata;
            if (wr && sel == SEL_LBASE) lbase_q <= pwdata;
            if (wr && sel == SEL_CTRL)  ctrl_q  <= pwdata[CTRL_W-1:0];
            pulse_q <= wr && (sel == SEL_TIM || sel == SEL_CTRL);
        end
    end

    lcdc_irq #(.IRQ_W(IRQ_W)) irq_i (
        .clk      (clk),
        .rst      (rst),
        .set_i    (int_set),
        .mask_we  (wr && sel == SEL_MASK),
        .clr_we   (wr && sel == SEL_CLR),
        .wdata    (pwdata[IRQ_W-1:0]),
        .mask_q   (mask_q),
        .status_q (status_q),
        .irq      (irq)
    );

    lcdc_geom geom_i (
        .tim0   (timing_q[0]),
        .tim1   (timing_q[1]),
        .width  (panel_width),
        .height (panel_height)
    );

    always_comb begin
        case (sel)
            SEL_TIM:   prdata = timing_q[idx[1:0]];
            SEL_UBASE: prdata = ubase_q;
            SEL_LBASE: prdata = lbase_q;
            SEL_MASK:  prdata = DATA_W'(mask_q);
            SEL_CTRL:  prdata = DATA_W'(ctrl_q);
            SEL_RAW:   prdata = DATA_W'(status_q);
            SEL_MSKD:  prdata = DATA_W'(status_q & mask_q);
            SEL_ID:    prdata = DATA_W'(id_byte(NEW_MAP, idx));
            default:   prdata = '0;
        endcase
    end

    assign cf         = unpack_ctrl(ctrl_q);
    assign disp_en    = cf.enable && cf.power;
    assign bpp_mode   = cf.bpp;
    assign bgr        = cf.bgr;
    assign be_byte    = cf.be_byte;
    assign be_pixel   = cf.be_pix;
    assign upper_base = ubase_q;
    assign lower_base = lbase_q;
    assign cfg_pulse  = pulse_q;
endmodule

// File: rtl/lcd_regif_chk.sv
module lcd_regif_chk #(
    parameter bit NEW_MAP = 1'b0,
    parameter int IRQ_W   = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [11:0] paddr,
    input logic [31:0] pwdata,
    input logic [IRQ_W-1:0] int_set,
    input logic        irq,
    input logic        disp_en,
    input logic [10:0] panel_width,
    input logic [10:0] panel_height,
    input logic [31:0] upper_base,
    input logic        cfg_pulse
);
    localparam logic [9:0] CTRL_WORD = NEW_MAP ? 10'd6 : 10'd7;

    logic       wr_c;
    logic [9:0] wd_c;
    assign wr_c = psel && penable && pwrite;
    assign wd_c = paddr[11:2];

    // R4
    width_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_c && wd_c == 10'd0) |=> panel_width == {$past(pwdata[7:2]) + 7'd1, 4'b0000});

    // R4
    height_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_c && wd_c == 10'd1) |=> panel_height == 11'($past(pwdata[9:0])) + 11'd1);

    // R5
    enable_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_c && wd_c == CTRL_WORD) |=> disp_en == ($past(pwdata[0]) && $past(pwdata[11])));

    // R11
    pulse_on_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_c && (wd_c < 10'd4 || wd_c == CTRL_WORD)) |=> cfg_pulse);

    // R11
    pulse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_c |=> !cfg_pulse);

    // R8
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_c && wd_c == 10'd10 && pwdata[IRQ_W-1:0] == '1 && int_set == '0) |=> !irq);

    // R10
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_c && wd_c > 10'd12 && paddr < 12'hFE0) |=> $stable(upper_base));
endmodule

bind lcd_regif lcd_regif_chk #(.NEW_MAP(NEW_MAP), .IRQ_W(IRQ_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .psel         (psel),
    .penable      (penable),
    .pwrite       (pwrite),
    .paddr        (paddr),
    .pwdata       (pwdata),
    .int_set      (int_set),
    .irq          (irq),
    .disp_en      (disp_en),
    .panel_width  (panel_width),
    .panel_height (panel_height),
    .upper_base   (upper_base),
    .cfg_pulse    (cfg_pulse)
);

// File: tb/lcd_regif_tb_top.sv
module lcd_regif_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  int_set = '0;

    logic [31:0] rd_o, rd_n;
    logic        irq_o, irq_n, en_o, en_n, bgr_o, bgr_n, bb_o, bb_n, bp_o, bp_n;
    logic        pl_o, pl_n;
    logic [2:0]  bpp_o, bpp_n;
    logic [10:0] w_o, w_n, h_o, h_n;
    logic [31:0] ub_o, ub_n, lb_o, lb_n;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    lcd_regif #(.NEW_MAP(1'b0)) dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(rd_o), .int_set(int_set),
        .irq(irq_o), .disp_en(en_o), .bpp_mode(bpp_o), .bgr(bgr_o),
        .be_byte(bb_o), .be_pixel(bp_o), .panel_width(w_o), .panel_height(h_o),
        .upper_base(ub_o), .lower_base(lb_o), .cfg_pulse(pl_o)
    );

    lcd_regif #(.NEW_MAP(1'b1)) dut_n (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(rd_n), .int_set(int_set),
        .irq(irq_n), .disp_en(en_n), .bpp_mode(bpp_n), .bgr(bgr_n),
        .be_byte(bb_n), .be_pixel(bp_n), .panel_width(w_n), .panel_height(h_n),
        .upper_base(ub_n), .lower_base(lb_n), .cfg_pulse(pl_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] vo, output logic [31:0] vn);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        vo = rd_o; vn = rd_n;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] a, b;
        check("R1 width", 32'(w_o), 32'd16);
        check("R1 height", 32'(h_o), 32'd1);
        check("R1 enable", 32'(en_o), 32'd0);
        check("R1 irq", 32'(irq_o), 32'd0);
        check("R1 pulse", 32'(pl_o), 32'd0);
        bus_read(12'h000, a, b);
        check("R1 timing0", a, 32'd0);
    endtask

    task automatic t_storage;
        logic [31:0] a, b;
        for (int k = 0; k < 6; k++) bus_write(12'(k * 4), 32'hA5000000 | 32'(k * 17));
        for (int k = 0; k < 6; k++) begin
            bus_read(12'(k * 4), a, b);
            check("R2 readback", a, 32'hA5000000 | 32'(k * 17));
        end
        check("R2 upper_base", ub_o, 32'hA5000044);
        check("R2 lower_base", lb_o, 32'hA5000055);
        bus_read(12'h02C, a, b);
        check("R10 word11 zero", a, 32'd0);
        bus_read(12'h030, a, b);
        check("R10 word12 zero", a, 32'd0);
    endtask

    task automatic t_geometry;
        bus_write(12'h000, 32'h0000_00FC);
        check("R4 width max", 32'(w_o), 32'd1024);
        check("R11 pulse timing", 32'(pl_o), 32'd1);
        @(negedge clk);
        check("R11 pulse single", 32'(pl_o), 32'd0);
        bus_write(12'h000, 32'hFFFF_FF13);
        check("R4 width ignores bits", 32'(w_o), 32'd80);
        bus_write(12'h004, 32'h0000_03FF);
        check("R4 height max", 32'(h_o), 32'd1024);
        bus_write(12'h004, 32'hFFFF_FD3F);
        check("R4 height ignores bits", 32'(h_o), 32'd320);
        bus_write(12'h004, 32'h0000_0C00);
        check("R4 height min", 32'(h_o), 32'd1);
    endtask

    task automatic t_variant;
        logic [31:0] a, b;
        bus_write(12'h018, 32'h0000_0801);
        check("R3 new word6 is control", 32'(en_n), 32'd1);
        check("R3 old word6 is not control", 32'(en_o), 32'd0);
        check("R11 pulse new control", 32'(pl_n), 32'd1);
        check("R11 no pulse old mask", 32'(pl_o), 32'd0);
        bus_read(12'h018, a, b);
        check("R3 old mask value", a, 32'd1);
        check("R6 new control readback", b, 32'h801);
        bus_write(12'h018, 32'd0);
    endtask

    task automatic t_control;
        logic [31:0] a, b;
        bus_write(12'h01C, 32'h0000_0001);
        check("R5 enable only", 32'(en_o), 32'd0);
        bus_write(12'h01C, 32'h0000_0800);
        check("R5 power only", 32'(en_o), 32'd0);
        bus_write(12'h01C, 32'h0000_0801);
        check("R5 both set", 32'(en_o), 32'd1);
        bus_write(12'h01C, 32'hFFFF_F70E);
        check("R6 bpp", 32'(bpp_o), 32'd7);
        check("R6 bgr", 32'(bgr_o), 32'd1);
        check("R6 be_byte", 32'(bb_o), 32'd1);
        check("R6 be_pixel", 32'(bp_o), 32'd1);
        check("R5 power cleared", 32'(en_o), 32'd0);
        bus_read(12'h01C, a, b);
        check("R6 upper bits zero", a, 32'h70E);
        bus_write(12'h01C, 32'h0000_0104);
        check("R6 bpp two", 32'(bpp_o), 32'd2);
        check("R6 be_pixel off", 32'(bp_o), 32'd0);
        bus_write(12'h01C, 32'd0);
    endtask

    task automatic t_irq;
        logic [31:0] a, b;
        bus_write(12'h018, 32'h0000_0005);
        @(negedge clk);
        int_set = 4'b0011;
        @(negedge clk);
        int_set = 4'b0000;
        bus_read(12'h020, a, b);
        check("R7 raw status", a, 32'h3);
        bus_read(12'h024, a, b);
        check("R7 masked status", a, 32'h1);
        check("R7 irq high", 32'(irq_o), 32'd1);
        bus_write(12'h028, 32'h0000_0001);
        check("R8 cleared irq", 32'(irq_o), 32'd0);
        bus_read(12'h020, a, b);
        check("R8 one bit left", a, 32'h2);
        @(negedge clk);
        int_set = 4'b0010;
        bus_write(12'h028, 32'h0000_0002);
        int_set = 4'b0000;
        bus_read(12'h020, a, b);
        check("R8 set wins", a, 32'h2);
        bus_write(12'h028, 32'hFFFF_FFFF);
        bus_read(12'h020, a, b);
        check("R8 clear all", a, 32'h0);
        bus_write(12'h018, 32'd0);
    endtask

    task automatic t_ident;
        logic [31:0] a, b;
        bus_read(12'hFE0, a, b);
        check("R9 old id0", a, 32'h10);
        check("R9 new id0", b, 32'h11);
        bus_read(12'hFE8, a, b);
        check("R9 old id2", a, 32'h04);
        check("R9 new id2", b, 32'h24);
        bus_read(12'hFF4, a, b);
        check("R9 id5", a, 32'hF0);
        bus_read(12'hFFC, a, b);
        check("R9 id7", b, 32'hB1);
    endtask

    task automatic t_unmapped;
        logic [31:0] a, b;
        bus_write(12'h400, 32'hDEAD_BEEF);
        check("R10 no pulse unmapped", 32'(pl_o), 32'd0);
        check("R10 base kept", ub_o, 32'hA5000044);
        bus_read(12'h400, a, b);
        check("R10 unmapped reads zero", a, 32'd0);
        bus_write(12'h020, 32'hFFFF_FFFF);
        check("R11 no pulse status write", 32'(pl_o), 32'd0);
        bus_read(12'h020, a, b);
        check("R10 raw status read-only", a, 32'd0);
        bus_write(12'h010, 32'h1234_5678);
        check("R11 no pulse base write", 32'(pl_o), 32'd0);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_storage();
        t_geometry();
        t_variant();
        t_control();
        t_irq();
        t_ident();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule